// File: doc/BRIEF.md
# UART Receive Flag Clear Sequencer

This block keeps the five receive-side condition flags of a UART status register: parity error, framing error, noise, overrun and idle line. The receiver raises a flag with a one-cycle event pulse on that flag's input bit. The flag then stays set until a reader clears it with a two-step sequence. The reader first reads the status register, and at some later point reads the data register.

A status-read strobe arms a pending clear and takes a snapshot of the flags that are set at that edge. The next data-read strobe clears the snapshotted flags and nothing else. Any amount of other bus traffic may fall between the two reads without cancelling the armed clear. The block has no notion of which master issued a read, so a processor read and a DMA read behave the same. Masking applied by software to the returned status value has no effect, because the strobe alone arms the sequence.

Top module: `uart_rx_flag_clear`

## Requirements
- R1: `flags` bit 0 is parity, bit 1 framing, bit 2 noise, bit 3 overrun and bit 4 idle line. A one-cycle pulse on `evt_set[i]` makes `flags[i]` read 1 after the next clock edge, and the flag then holds until a clear sequence removes it.
- R2: A `stat_rd` strobe followed by a later `data_rd` strobe clears every flag that was 1 at the `stat_rd` edge. The clear takes effect at the `data_rd` edge.
- R3: A `data_rd` strobe with no armed sequence leaves every flag unchanged.
- R4: Cycles with `other_acc` strobes, or idle cycles, between the status read and the data read do not cancel the armed clear.
- R5: A flag that becomes set at the same edge as the status read, or any time after it, is not cleared by the data read that completes the sequence.
- R6: When a set pulse and a clear land on the same flag at the same edge, the flag ends up 1.
- R7: A second `stat_rd` before the data read replaces the snapshot with the flags that are set at that second read.
- R8: Once a data read completes a sequence, the armed state is dropped. A further lone `data_rd` then clears nothing.
- R9: When `stat_rd` and `data_rd` are high in the same cycle, the data read completes any sequence that is already armed. The status read then arms a new sequence whose snapshot is the flags left after that clear.
- R10: A synchronous active-high `rst` clears all flags, the snapshot and the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_rd | input | 1 | One-cycle strobe: status register read |
| data_rd | input | 1 | One-cycle strobe: data register read |
| other_acc | input | 1 | One-cycle strobe: any other bus access |
| evt_set | input | NUM_FLAGS | Receiver set pulses, one bit per flag |
| flags | output | NUM_FLAGS | Current flag vector |

## Verification
The clear sequence is tried in several orders, and each order tells a different fault apart:
- A plain status read followed by a data read.
- The same sequence with a long run of other-register accesses between the two reads, which separates a pending clear that is held from one that is dropped.
- A lone data read, and a repeated data read after a completed sequence, which expose a clear that does not depend on arming.
- Flags raised between the two reads, and raised on the very edge of a clear, which distinguish a snapshot clear from a clear of the whole vector and confirm that the set pulse wins.
- A double status read, and status and data reads in the same cycle, which check snapshot replacement and the ordering of completion against re-arming.
- A reset issued while a sequence is armed, which shows the pending state is dropped.

// File: rtl/uart_flagclr_pkg.sv
package uart_flagclr_pkg;

   localparam int unsigned UFC_NUM_FLAGS = 5;

   localparam int unsigned UFC_IDX_PARITY  = 0;
   localparam int unsigned UFC_IDX_FRAMING = 1;
   localparam int unsigned UFC_IDX_NOISE   = 2;
   localparam int unsigned UFC_IDX_OVERRUN = 3;
   localparam int unsigned UFC_IDX_IDLE    = 4;

   typedef enum logic {
      ARM_IDLE    = 1'b0,
      ARM_PENDING = 1'b1
   } arm_state_e;

endpackage

// File: rtl/ufc_flag_cell.sv
module ufc_flag_cell (
   input  logic clk,
   input  logic rst,
   input  logic set_pulse,
   input  logic clr_pulse,
   output logic q
);

   // set has priority over clear
   always_ff @(posedge clk) begin
      if (rst)            q <= 1'b0;
      else if (set_pulse) q <= 1'b1;
      else if (clr_pulse) q <= 1'b0;
   end

endmodule

// File: rtl/ufc_arm_ctrl.sv
module ufc_arm_ctrl
   import uart_flagclr_pkg::*;
#(
   parameter int unsigned NUM_FLAGS = UFC_NUM_FLAGS
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 stat_rd,
   input  logic                 data_rd,
   input  logic [NUM_FLAGS-1:0] flags_q,
   output logic [NUM_FLAGS-1:0] clr_mask,
   output logic                 armed
);

   arm_state_e           state_q;
   logic [NUM_FLAGS-1:0] snap_q;
   logic                 complete;

   assign complete = data_rd && (state_q == ARM_PENDING);
   assign clr_mask = complete ? snap_q : '0;
   assign armed    = (state_q == ARM_PENDING);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ARM_IDLE;
         snap_q  <= '0;
      end else if (stat_rd) begin
         // the snapshot excludes flags being cleared at this same edge
         state_q <= ARM_PENDING;
         snap_q  <= flags_q & ~clr_mask;
      end else if (complete) begin
         state_q <= ARM_IDLE;
         snap_q  <= '0;
      end
   end

endmodule

// File: rtl/uart_rx_flag_clear.sv
module uart_rx_flag_clear
   import uart_flagclr_pkg::*;
#(
   parameter int unsigned NUM_FLAGS = UFC_NUM_FLAGS
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 stat_rd,
   input  logic                 data_rd,
   input  logic                 other_acc,
   input  logic [NUM_FLAGS-1:0] evt_set,
   output logic [NUM_FLAGS-1:0] flags
);

   generate
      if (NUM_FLAGS < 1 || NUM_FLAGS > 32) begin : g_bad_width
         $error("uart_rx_flag_clear: NUM_FLAGS must be 1..32");
      end
   endgenerate

   logic [NUM_FLAGS-1:0] clr_mask;
   logic                 armed;

   ufc_arm_ctrl #(.NUM_FLAGS(NUM_FLAGS)) u_arm (
      .clk      (clk),
      .rst      (rst),
      .stat_rd  (stat_rd),
      .data_rd  (data_rd),
      .flags_q  (flags),
      .clr_mask (clr_mask),
      .armed    (armed)
   );

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      ufc_flag_cell u_cell (
         .clk       (clk),
         .rst       (rst),
         .set_pulse (evt_set[i]),
         .clr_pulse (clr_mask[i]),
         .q         (flags[i])
      );
   end

endmodule

// File: rtl/ufc_checker.sv
module ufc_checker #(
   parameter int unsigned NUM_FLAGS = 5
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 stat_rd,
   input logic                 data_rd,
   input logic                 other_acc,
   input logic [NUM_FLAGS-1:0] evt_set,
   input logic [NUM_FLAGS-1:0] flags,
   input logic                 armed
);

   AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      (|evt_set) |=> ((flags & $past(evt_set)) == $past(evt_set))); // R6

   AST_NO_LONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
      !(data_rd && armed) |=> ((flags & $past(flags)) == $past(flags))); // R3

   AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (armed && other_acc && !data_rd) |=> armed); // R4

   AST_DISARM_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
      (armed && data_rd && !stat_rd) |=> !armed); // R8

   AST_STATUS_ARMS: assert property (@(posedge clk) disable iff (rst)
      stat_rd |=> armed); // R2

endmodule

bind uart_rx_flag_clear ufc_checker #(.NUM_FLAGS(NUM_FLAGS)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .stat_rd   (stat_rd),
   .data_rd   (data_rd),
   .other_acc (other_acc),
   .evt_set   (evt_set),
   .flags     (flags),
   .armed     (armed)
);

// File: tb/uart_rx_flag_clear_tb.sv
module uart_rx_flag_clear_tb;

   localparam int NF = 5;
   localparam int NV = 24;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          stat_rd = 1'b0;
   logic          data_rd = 1'b0;
   logic          other_acc = 1'b0;
   logic [NF-1:0] evt_set = '0;
   logic [NF-1:0] flags;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   uart_rx_flag_clear #(.NUM_FLAGS(NF)) u_dut (
      .clk(clk), .rst(rst), .stat_rd(stat_rd), .data_rd(data_rd),
      .other_acc(other_acc), .evt_set(evt_set), .flags(flags)
   );

   // {stat, data, other, set[4:0], expected flags[4:0]}; bit0 P,1 F,2 N,3 O,4 I
   localparam logic [12:0] VEC [NV] = '{
      {3'b000, 5'b00011, 5'b00011},  // R1 set P,F
      {3'b100, 5'b00000, 5'b00011},  // arm, snap P,F
      {3'b001, 5'b00000, 5'b00011},  // R4 other access
      {3'b001, 5'b00000, 5'b00011},  // R4
      {3'b000, 5'b01000, 5'b01011},  // R5 overrun after arm
      {3'b010, 5'b00000, 5'b01000},  // R2/R5 clear snapshot only
      {3'b010, 5'b00000, 5'b01000},  // R3/R8 lone data read
      {3'b000, 5'b10000, 5'b11000},  // idle set
      {3'b100, 5'b00000, 5'b11000},  // arm snap I,O
      {3'b010, 5'b01000, 5'b01000},  // R6 set O wins over clear
      {3'b010, 5'b00000, 5'b01000},  // R8 disarmed
      {3'b100, 5'b00000, 5'b01000},  // arm snap O
      {3'b000, 5'b00100, 5'b01100},  // noise set
      {3'b100, 5'b00000, 5'b01100},  // R7 re-arm snap O,N
      {3'b010, 5'b00000, 5'b00000},  // R7 both cleared
      {3'b000, 5'b11111, 5'b11111},  // all set
      {3'b110, 5'b00000, 5'b11111},  // R9 not armed: arm only
      {3'b010, 5'b00000, 5'b00000},  // R2 clear all
      {3'b010, 5'b00000, 5'b00000},  // R3
      {3'b000, 5'b00001, 5'b00001},  // P set
      {3'b100, 5'b00000, 5'b00001},  // arm snap P
      {3'b000, 5'b00010, 5'b00011},  // F set
      {3'b110, 5'b00000, 5'b00010},  // R9 clear P, re-arm snap F
      {3'b010, 5'b00000, 5'b00000}   // R9 new snapshot cleared
   };

   task automatic check(input string req, input logic [NF-1:0] got, input logic [NF-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: flags=%b expected=%b", req, got, exp);
      end
   endtask

   task automatic cyc(input logic s, input logic d, input logic o, input logic [NF-1:0] e);
      @(negedge clk);
      stat_rd = s; data_rd = d; other_acc = o; evt_set = e;
      @(posedge clk);
      #2;
      stat_rd = 1'b0; data_rd = 1'b0; other_acc = 1'b0; evt_set = '0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R10 reset state", flags, '0);
      @(negedge clk);
      rst = 1'b0;

      for (int k = 0; k < NV; k++) begin
         cyc(VEC[k][12], VEC[k][11], VEC[k][10], VEC[k][9:5]);
         check($sformatf("R1/R2 vector %0d", k), flags, VEC[k][4:0]);
      end

      // R4: long run of other accesses and idle cycles between the reads
      cyc(1'b0, 1'b0, 1'b0, 5'b10100);
      cyc(1'b1, 1'b0, 1'b0, 5'b00000);
      for (int k = 0; k < 60; k++) cyc(1'b0, 1'b0, k[0], 5'b00000);
      check("R4 held across traffic", flags, 5'b10100);
      cyc(1'b0, 1'b1, 1'b0, 5'b00000);
      check("R4 clear after traffic", flags, 5'b00000);

      // R5: flag set on the status-read edge is outside the snapshot
      cyc(1'b0, 1'b0, 1'b0, 5'b00001);
      cyc(1'b1, 1'b0, 1'b0, 5'b00010);
      cyc(1'b0, 1'b1, 1'b0, 5'b00000);
      check("R5 same-edge set survives", flags, 5'b00010);
      cyc(1'b1, 1'b0, 1'b0, 5'b00000);
      cyc(1'b0, 1'b1, 1'b0, 5'b00000);
      check("R2 cleanup", flags, 5'b00000);

      // R10: reset while armed drops the pending clear
      cyc(1'b0, 1'b0, 1'b0, 5'b01000);
      cyc(1'b1, 1'b0, 1'b0, 5'b00000);
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #2;
      check("R10 reset clears flags", flags, 5'b00000);
      @(negedge clk); rst = 1'b0;
      cyc(1'b0, 1'b0, 1'b0, 5'b01000);
      cyc(1'b0, 1'b1, 1'b0, 5'b00000);
      check("R10 reset dropped armed state", flags, 5'b01000);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule